// File: doc/BRIEF.md
# Testable Timing-Error Detection Slice

This block is a cycle-level model of the error-detection logic for one stage of a latch-based, timing-resilient pipeline. Test controls are added to it. A fast system clock `clk` samples everything. The stage's phase clock and its sampling enable arrive as ordinary inputs. Each data bit feeds a transition detector. A detector raises its flag when the bit differs from its value one `clk` cycle earlier.

Flags are grouped three at a time into asymmetric set/clear elements, which remember a violation seen while the phase clock is high. The elements of one sampling group are ORed together. A sampling register, held at zero while its enable is low, captures that OR, and the stage error is reported on a complementary rail pair.

Two global test inputs give the controllability needed to exercise paths that only a violation would reach:
- `force_tv` drives every flag high, whatever the data.
- `test_sel` swaps each set/clear element for an AND-based checker element, which sets only when all three of its flags are high.

A six-bit observation word exposes the per-group error rails and a per-group AND of the flags. In every mode, a fault-free stage with quiet data gives a fixed gold pattern.

Top module: `ted_slice`

## Requirements
- R1: After the active-low synchronous reset `rst_n`, and with quiet data and both test inputs low, the outputs read `err_t`=0, `err_f`=1, `obs`=6'b001100.
- R2: With `test_sel`=0, a change in any data bit while `phase` is high produces an error in that bit's group once `sample` is raised.
- R3: Once set during a phase-high interval, a group's element keeps its value while `phase` stays high, so an error seen early in the phase is still reported after several cycles of stable data.
- R4: A set/clear element clears whenever `phase` is low. A data change seen only while `phase` was low is never reported.
- R5: A group's sampling register reads 0 in any cycle after `sample` was low, so no error is reported without `sample`.
- R6: `err_t`=1 and `err_f`=0 when at least one group register is set. Otherwise `err_t`=0 and `err_f`=1.
- R7: With `force_tv`=1, every flag is 1 regardless of the data. Every group reports an error at sampling, and both AND lines read 1.
- R8: With `test_sel`=1, a group reports an error only if all three bits of one element (bits 3k..3k+2) changed. A single-bit change, or changes spread across elements, give no error.
- R9: The layout of `obs` is as follows. `obs[5:4]` holds the group true rails (bit 4 = group 0). `obs[3:2]` holds their complements (bit 2 = group 0). `obs[1:0]` holds the AND of all flags of each group (bit 0 = group 0). The gold pattern is 6'b001100 without `force_tv` and 6'b110011 with it.
- R10: Group 0 covers data bits 5..0 and group 1 covers bits 11..6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 1 | Stage phase clock, sampled by `clk` |
| sample | input | 1 | Sampling-register enable, reset while low |
| test_sel | input | 1 | Forward AND-checker elements instead of set/clear elements |
| force_tv | input | 1 | Force every transition flag high |
| din | input | 12 | Latch data bits watched by the detectors |
| err_t | output | 1 | Error true rail |
| err_f | output | 1 | Error false rail |
| obs | output | 6 | Observation word (see R9) |

## Verification
The detection path is tried with four kinds of data pattern:
- Quiet data separates a real flag from a spurious one.
- Single-bit changes at the group boundaries (bits 0, 5, 6 and 11) show the group mapping.
- A change made while `phase` is low shows the clear behaviour.
- A change with `sample` held low shows the sampling gate.

In checker mode, three patterns are compared:
- a single bit
- two bits in adjacent elements
- a full element triplet

Only the triplet may raise an error, which separates the AND path from the OR path. The forced-violation modes are run both with stable and with changing data, to show that the data has no say there.

// File: rtl/ted_pkg.sv
package ted_pkg;

   // Mode encoding follows {test_sel, force_tv}
   typedef enum logic [1:0] {
      MODE_NM   = 2'b00,
      MODE_NMTV = 2'b01,
      MODE_TM   = 2'b10,
      MODE_TMTV = 2'b11
   } ted_mode_e;

   function automatic logic mode_uses_checker(ted_mode_e m);
      return (m == MODE_TM) || (m == MODE_TMTV);
   endfunction

   function automatic logic mode_forces_flags(ted_mode_e m);
      return (m == MODE_NMTV) || (m == MODE_TMTV);
   endfunction

endpackage

// File: rtl/ted_flag_bank.sv
module ted_flag_bank #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   input  logic         force_i,
   output logic [W-1:0] flag_o
);

   logic [W-1:0] din_dly;

   always_ff @(posedge clk) begin
      if (!rst_n) din_dly <= '0;
      else        din_dly <= din;
   end

   for (genvar i = 0; i < W; i++) begin : g_det
      assign flag_o[i] = force_i | (din[i] ^ din_dly[i]);
   end

endmodule

// File: rtl/ted_cel_array.sv
module ted_cel_array #(
   parameter int W      = 12,
   parameter int CEL_IN = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                phase,
   input  logic                sel_chk,
   input  logic [W-1:0]        flag_i,
   output logic [W/CEL_IN-1:0] fwd_o
);

   localparam int N_CEL = W / CEL_IN;

   for (genvar k = 0; k < N_CEL; k++) begin : g_cel
      logic [CEL_IN-1:0] slice;
      logic              cel_r;
      logic              chk_r;

      assign slice = flag_i[k*CEL_IN +: CEL_IN];

      // asymmetric element: clears on low phase, sets on any flag
      always_ff @(posedge clk) begin
         if (!rst_n)       cel_r <= 1'b0;
         else if (!phase)  cel_r <= 1'b0;
         else if (|slice)  cel_r <= 1'b1;
      end

      // checker element: clears on low phase, sets only on all flags
      always_ff @(posedge clk) begin
         if (!rst_n)       chk_r <= 1'b0;
         else if (!phase)  chk_r <= 1'b0;
         else if (&slice)  chk_r <= 1'b1;
      end

      assign fwd_o[k] = sel_chk ? chk_r : cel_r;
   end

endmodule

// File: rtl/ted_err_sampler.sv
module ted_err_sampler #(
   parameter int N_CEL       = 4,
   parameter int CEL_PER_GRP = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sample,
   input  logic [N_CEL-1:0]              fwd_i,
   output logic [N_CEL/CEL_PER_GRP-1:0]  grp_err_o
);

   localparam int N_GRP = N_CEL / CEL_PER_GRP;

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      logic any_set;
      logic q_r;

      assign any_set = |fwd_i[g*CEL_PER_GRP +: CEL_PER_GRP];

      // register held at zero while its enable is low
      always_ff @(posedge clk) begin
         if (!rst_n)       q_r <= 1'b0;
         else if (!sample) q_r <= 1'b0;
         else              q_r <= any_set;
      end

      assign grp_err_o[g] = q_r;
   end

endmodule

// File: rtl/ted_slice.sv
module ted_slice
   import ted_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int CEL_IN   = 3,
   parameter int GRP_BITS = 6
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              phase,
   input  logic                              sample,
   input  logic                              test_sel,
   input  logic                              force_tv,
   input  logic [DATA_W-1:0]                 din,
   output logic                              err_t,
   output logic                              err_f,
   output logic [3*(DATA_W/GRP_BITS)-1:0]    obs
);

   localparam int N_CEL       = DATA_W / CEL_IN;
   localparam int N_GRP       = DATA_W / GRP_BITS;
   localparam int CEL_PER_GRP = GRP_BITS / CEL_IN;

   if (DATA_W % GRP_BITS != 0) begin : g_bad_grp
      $error("DATA_W must be a multiple of GRP_BITS");
   end
   if (GRP_BITS % CEL_IN != 0) begin : g_bad_cel
      $error("GRP_BITS must be a multiple of CEL_IN");
   end
   if (CEL_IN < 1) begin : g_bad_in
      $error("CEL_IN must be at least 1");
   end

   ted_mode_e          mode;
   logic [DATA_W-1:0]  flag;
   logic [N_CEL-1:0]   fwd;
   logic [N_GRP-1:0]   grp_err;
   logic [N_GRP-1:0]   and_line;

   assign mode = ted_mode_e'({test_sel, force_tv});

   ted_flag_bank #(.W(DATA_W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (din),
      .force_i (mode_forces_flags(mode)),
      .flag_o  (flag)
   );

   ted_cel_array #(.W(DATA_W), .CEL_IN(CEL_IN)) u_cels (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase   (phase),
      .sel_chk (mode_uses_checker(mode)),
      .flag_i  (flag),
      .fwd_o   (fwd)
   );

   ted_err_sampler #(.N_CEL(N_CEL), .CEL_PER_GRP(CEL_PER_GRP)) u_samp (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (sample),
      .fwd_i     (fwd),
      .grp_err_o (grp_err)
   );

   for (genvar g = 0; g < N_GRP; g++) begin : g_and
      assign and_line[g] = &flag[g*GRP_BITS +: GRP_BITS];
   end

   assign err_t = |grp_err;
   assign err_f = ~|grp_err;
   assign obs   = {grp_err, ~grp_err, and_line};

endmodule

// File: rtl/ted_slice_chk.sv
module ted_slice_chk #(
   parameter int NG = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          phase,
   input logic          sample,
   input logic          force_tv,
   input logic          err_t,
   input logic          err_f,
   input logic [3*NG-1:0] obs
);

   AST_SAMPLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> (!err_t && err_f)); // R5

   AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !phase |-> ##2 !err_t); // R4

   AST_TV_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(force_tv) && $past(phase) && sample) |=> err_t); // R7

   AST_TV_AND_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      force_tv |-> (&obs[NG-1:0])); // R7

endmodule

bind ted_slice ted_slice_chk #(.NG(DATA_W/GRP_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .phase    (phase),
   .sample   (sample),
   .force_tv (force_tv),
   .err_t    (err_t),
   .err_f    (err_f),
   .obs      (obs)
);

// File: tb/tb_ted_slice.sv
module tb_ted_slice;

   localparam int W  = 12;
   localparam int NG = 2;

   logic          clk = 1'b0;
   logic          rst_n, phase, sample, test_sel, force_tv;
   logic [W-1:0]  din;
   logic          err_t, err_f;
   logic [3*NG-1:0] obs;

   always #10 clk = ~clk;

   ted_slice dut (
      .clk(clk), .rst_n(rst_n), .phase(phase), .sample(sample),
      .test_sel(test_sel), .force_tv(force_tv), .din(din),
      .err_t(err_t), .err_f(err_f), .obs(obs)
   );

   typedef struct {
      logic [7:0] v;
      string      tag;
   } exp_t;

   exp_t       sb[$];
   event       chk_ev;
   int         n_chk  = 0;
   int         n_fail = 0;
   logic [W-1:0] prev_din;

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(chk_ev);
         while (sb.size() > 0) begin
            exp_t e;
            logic [7:0] act;
            e   = sb.pop_front();
            act = {err_t, err_f, obs};
            n_chk++;
            if (act[7:6] !== e.v[7:6]) begin
               n_fail++;
               $display("FAIL %s rails: got %b expected %b", e.tag, act[7:6], e.v[7:6]);
            end
            n_chk++;
            if (act[5:0] !== e.v[5:0]) begin
               n_fail++;
               $display("FAIL %s obs: got %b expected %b", e.tag, act[5:0], e.v[5:0]);
            end
         end
      end
   end

   // driver: one phase window, expected result computed from the requirements
   task automatic window(input logic [W-1:0] nd, input logic tmv, input logic tvv,
                         input logic early, input logic smp, input string tag);
      logic [W-1:0]  chg;
      logic [NG-1:0] ge;
      exp_t          e;
      chg = early ? '0 : (nd ^ prev_din);
      for (int g = 0; g < NG; g++) begin
         ge[g] = tvv;
         for (int c = 0; c < 2; c++) begin
            if (tmv ? (&chg[g*6 + c*3 +: 3]) : (|chg[g*6 + c*3 +: 3])) ge[g] = 1'b1;
         end
         if (!smp) ge[g] = 1'b0;
      end
      @(negedge clk);
      test_sel = tmv; force_tv = tvv; din = nd; phase = !early;
      if (early) begin
         @(negedge clk);
         phase = 1'b1;
      end
      prev_din = nd;
      repeat (2) @(negedge clk);
      sample = smp;
      @(negedge clk);
      e.v   = {|ge, ~|ge, ge, ~ge, (tvv ? 2'b11 : 2'b00)};
      e.tag = tag;
      sb.push_back(e);
      -> chk_ev;
      sample = 1'b0; phase = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      exp_t e;
      rst_n = 1'b0; phase = 1'b0; sample = 1'b0;
      test_sel = 1'b0; force_tv = 1'b0; din = '0;
      prev_din = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      e.v = {2'b01, 6'b001100}; e.tag = "R1 reset state";
      sb.push_back(e);
      -> chk_ev;

      window(12'h000, 0, 0, 0, 1, "R2 quiet data NM");
      window(12'h001, 0, 0, 0, 1, "R2 R3 bit0 change held");
      window(12'h801, 0, 0, 0, 1, "R10 bit11 group1");
      window(12'h821, 0, 0, 0, 1, "R10 bit5 group0");
      window(12'h861, 0, 0, 0, 1, "R10 bit6 group1");
      window(12'h000, 0, 0, 1, 1, "R4 change while phase low");
      window(12'hFFF, 0, 0, 0, 0, "R5 sample held low");
      window(12'hFFE, 1, 0, 0, 1, "R8 TM single bit");
      window(12'hFF2, 1, 0, 0, 1, "R8 TM spread across elements");
      window(12'hE32, 1, 0, 0, 1, "R8 TM full triplet");
      window(12'hE32, 1, 1, 0, 1, "R7 R9 TMTV stable data");
      window(12'h000, 0, 1, 0, 1, "R7 NMTV changing data");
      window(12'h000, 0, 0, 0, 1, "R6 R9 NM gold");
      window(12'h041, 0, 0, 0, 1, "R6 both groups");

      #1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule